// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges level-sensitive interrupt requests from a set of devices onto a few shared interrupt lines. Each device drives four request pins. The block keeps the last level it saw on every pin and acts only when a pin changes. A changed pin is routed to one shared line through two steps. The first step is a fixed slot-dependent swizzle, taken once more for devices that sit behind a bridge. The second step is a programmable table that maps the resulting root pin to a line. A rise adds one to that line's reference counter and a fall subtracts one. A line is asserted while its counter is non-zero, so each line acts as a wired-OR of every pin routed onto it.

Requests are plain levels rather than a stream, so there is no valid/ready handshake and no back-pressure. A pin may change on any clock, and the block takes every change in the cycle it is sampled. The mapping table is read at the moment each change is counted. For that reason it should be changed only while the pins it affects are low.

Top module: `sirq_aggregator`

## Requirements
- R1: The request vector `irq_i` carries four pins per device, with device d pin p at bit d*4+p. All pins are sampled on every rising clock edge.
- R2: A pin whose sampled level equals its stored level causes no change to any counter or line.
- R3: A rise on a pin adds one to the counter of its mapped line and a fall subtracts one. The line output reflects the change right after the clock edge that samples the new level.
- R4: A line output is 1 exactly when its counter is non-zero, which makes the line the OR of the high pins mapped onto it.
- R5: While reset is low, and right after it is released, every stored level and every counter is zero and all lines are low.
- R6: For a device d below DIRECT_DEVS, on slot d of the root bus, the root pin of its pin p is (d + p) mod 4.
- R7: A device d at or above DIRECT_DEVS sits on slot s = d - DIRECT_DEVS behind a bridge on root slot BRIDGE_SLOT. Its pin p reaches root pin (BRIDGE_SLOT + ((s + p) mod 4)) mod 4.
- R8: Root pin r drives line `line_map_i[r*LW +: LW]`. The table is applied at the time each change is counted. A table entry of NUM_LINES or more discards the event.
- R9: When several pins change in the same cycle, all of their increments and decrements are summed into the counters in that cycle, so no event is lost.
- R10: A counter never goes below zero. A fall that would take it negative leaves it at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_DEV*4 | Request levels, device d pin p at bit d*4+p |
| line_map_i | input | 4*LW | Root pin to line table, LW = clog2(NUM_LINES) bits per entry |
| line_o | output | NUM_LINES | Shared interrupt lines |

## Verification
A stored level that drifts from the input shows up as a missed or doubled count. A counter that is off by one shows up as a line that stays high after its last pin falls, or one that drops while a pin is still high. Either fault reaches `line_o` on the first edge after the pin change that exposes it. The bench therefore compares every line against an arithmetic model after every single-cycle stimulus step. It sweeps every pin alone under two tables, then runs long sequences in which many pins change at once.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  // Root pin reached by pin p of device d, after the slot swizzle and, for
  // devices behind the bridge, a second swizzle at the bridge's slot.
  function automatic int root_pin(input int dev, input int pin,
                                  input int direct_devs, input int bridge_slot);
    int local_pin;
    if (dev < direct_devs) begin
      return (dev + pin) % 4;
    end
    local_pin = ((dev - direct_devs) + pin) % 4;
    return (bridge_slot + local_pin) % 4;
  endfunction
endpackage

// File: rtl/sirq_level_track.sv
module sirq_level_track #(
  parameter int NPINS = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] irq_i,
  output logic [NPINS-1:0] rise_o,
  output logic [NPINS-1:0] fall_o
);
  logic [NPINS-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= irq_i;
  end

  assign rise_o = irq_i & ~lvl_q;
  assign fall_o = ~irq_i & lvl_q;

  // R2: an unchanged request leaves the stored level untouched
  a_r2_same_level_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i == lvl_q) |=> $stable(lvl_q));
endmodule

// File: rtl/sirq_route.sv
module sirq_route #(
  parameter int NPINS       = 24,
  parameter int LW          = 2,
  parameter int DIRECT_DEVS = 4,
  parameter int BRIDGE_SLOT = 1
) (
  input  logic [4*LW-1:0]     line_map_i,
  output logic [NPINS*LW-1:0] line_idx_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int RP = sirq_pkg::root_pin(i / 4, i % 4, DIRECT_DEVS, BRIDGE_SLOT);
    assign line_idx_o[i*LW +: LW] = line_map_i[RP*LW +: LW];
  end
endmodule

// File: rtl/sirq_line_counter.sv
module sirq_line_counter #(
  parameter int NPINS   = 24,
  parameter int LW      = 2,
  parameter int CW      = 5,
  parameter int LINE_ID = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NPINS-1:0]    rise_i,
  input  logic [NPINS-1:0]    fall_i,
  input  logic [NPINS*LW-1:0] line_idx_i,
  output logic                line_o
);
  localparam logic [LW-1:0] ID = LW'(LINE_ID);
  localparam logic signed [CW+1:0] MAXV = (CW+2)'(NPINS);

  logic [CW-1:0] cnt_q, cnt_d, up, dn;
  logic signed [CW+1:0] sum;

  always_comb begin
    up = '0;
    dn = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (line_idx_i[i*LW +: LW] == ID) begin
        if (rise_i[i]) up = up + 1'b1;
        if (fall_i[i]) dn = dn + 1'b1;
      end
    end
    sum = $signed({2'b00, cnt_q}) + $signed({2'b00, up}) - $signed({2'b00, dn});
    if (sum < 0)         cnt_d = '0;
    else if (sum > MAXV) cnt_d = MAXV[CW-1:0];
    else                 cnt_d = sum[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign line_o = |cnt_q;

  // R3: with no routed event the count holds
  a_r3_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up == '0 && dn == '0) |=> $stable(cnt_q));
  // R3: a lone rise raises the line on the next cycle
  a_r3_rise_sets_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up != '0 && dn == '0) |=> line_o);
  // R10: a fall on an empty counter leaves it at zero
  a_r10_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && up == '0) |=> (cnt_q == '0));
  // R4: a line with nothing counted and nothing arriving is low next cycle
  a_r4_empty_line_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && up == '0) |=> !line_o);
endmodule

// File: rtl/sirq_aggregator.sv
module sirq_aggregator #(
  parameter int NUM_DEV     = 6,
  parameter int NUM_LINES   = 4,
  parameter int DIRECT_DEVS = 4,
  parameter int BRIDGE_SLOT = 1,
  localparam int NPINS      = NUM_DEV * 4,
  localparam int LW         = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CW         = $clog2(NPINS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NPINS-1:0]     irq_i,
  input  logic [4*LW-1:0]      line_map_i,
  output logic [NUM_LINES-1:0] line_o
);
  logic [NPINS-1:0]    rise, fall;
  logic [NPINS*LW-1:0] line_idx;

  sirq_level_track #(.NPINS(NPINS)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  sirq_route #(
    .NPINS(NPINS), .LW(LW), .DIRECT_DEVS(DIRECT_DEVS), .BRIDGE_SLOT(BRIDGE_SLOT)
  ) u_route (
    .line_map_i (line_map_i),
    .line_idx_o (line_idx)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    sirq_line_counter #(
      .NPINS(NPINS), .LW(LW), .CW(CW), .LINE_ID(l)
    ) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rise_i     (rise),
      .fall_i     (fall),
      .line_idx_i (line_idx),
      .line_o     (line_o[l])
    );
  end

  // R2: an unchanged request vector leaves every line as it was
  a_r2_lines_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i == $past(irq_i) && $stable(line_map_i)) |=> $stable(line_o));
  // R4: all pins low for two samples leaves no line asserted
  a_r4_all_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i == '0 && $past(irq_i) == '0 && $past(line_o) == '0) |=> (line_o == '0));
endmodule

// File: tb/sirq_aggregator_tb_top.sv
`timescale 1ns/1ps
module sirq_aggregator_tb_top;
  localparam int ND = 6, NL = 4, DD = 4, BS = 1;
  localparam int NP = ND * 4, LW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0]   irq = '0;
  logic [4*LW-1:0] lmap = '0;
  logic [NL-1:0]   line;

  int tests = 0, fails = 0;
  int mcnt [NL];
  logic [NP-1:0] mlvl = '0;
  int mmap [4];
  logic [31:0] lfsr = 32'hACE1_2468;

  always #2.5 clk = ~clk;

  sirq_aggregator #(.NUM_DEV(ND), .NUM_LINES(NL), .DIRECT_DEVS(DD), .BRIDGE_SLOT(BS))
    dut_i (.clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .line_map_i(lmap), .line_o(line));

  function automatic int rootp(input int d, input int p);
    if (d < DD) return (d + p) % 4;                 // R6
    return (BS + (((d - DD) + p) % 4)) % 4;         // R7
  endfunction

  task automatic set_map(input int m0, input int m1, input int m2, input int m3);
    mmap[0] = m0; mmap[1] = m1; mmap[2] = m2; mmap[3] = m3;
    for (int r = 0; r < 4; r++) lmap[r*LW +: LW] = LW'(mmap[r]);
  endtask

  task automatic check_lines(input string tag);
    for (int l = 0; l < NL; l++) begin
      logic exp;
      exp = (mcnt[l] != 0);
      tests++;
      if (line[l] !== exp) begin
        fails++;
        $display("FAIL %s line %0d actual %b expected %b", tag, l, line[l], exp);
      end
    end
  endtask

  task automatic clear_model();
    for (int l = 0; l < NL; l++) mcnt[l] = 0;
    mlvl = '0;
  endtask

  // Drive a new request vector at a falling edge and check one cycle later.
  task automatic step(input logic [NP-1:0] v, input string tag);
    int delta [NL];
    for (int l = 0; l < NL; l++) delta[l] = 0;
    for (int i = 0; i < NP; i++) begin
      if (v[i] != mlvl[i]) begin
        int ln;
        ln = mmap[rootp(i / 4, i % 4)];
        if (ln < NL) delta[ln] += v[i] ? 1 : -1;
      end
    end
    for (int l = 0; l < NL; l++) begin
      mcnt[l] += delta[l];
      if (mcnt[l] < 0) mcnt[l] = 0;                 // R10
    end
    mlvl = v;
    irq = v;
    @(negedge clk);
    check_lines(tag);
  endtask

  task automatic sweep(input string tag_d, input string tag_b);
    for (int i = 0; i < NP; i++) begin
      logic [NP-1:0] v;
      v = '0;
      v[i] = 1'b1;
      step(v, (i / 4 < DD) ? tag_d : tag_b);
      step('0, (i / 4 < DD) ? tag_d : tag_b);
    end
  endtask

  initial begin
    #200000;
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_model();
    set_map(0, 1, 2, 3);
    repeat (3) @(negedge clk);
    check_lines("R5 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_lines("R5 after release");

    // R6 / R7 single-pin sweep, identity table; R3 rise and fall
    sweep("R6 R3 direct swizzle", "R7 R3 bridged swizzle");
    // R8 reversed table
    set_map(3, 2, 1, 0);
    sweep("R8 reversed table", "R8 reversed table bridged");
    // R8 out-of-range entries are impossible with four lines; collapse table
    set_map(2, 2, 2, 2);
    step({NP{1'b1}}, "R8 R4 all pins on one line");
    step({NP{1'b1}}, "R2 repeated level");
    step({{(NP-1){1'b0}}, 1'b1}, "R4 OR holds with one pin left");
    step('0, "R4 last pin falls");

    // R9 many simultaneous changes under a rotated table
    set_map(1, 3, 0, 2);
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (k % 7 == 3) step(mlvl, "R2 no change");
      else            step(lfsr[NP-1:0], "R9 R1 simultaneous changes");
    end
    step('0, "R9 drain");

    // R10 fall on an empty counter via a table change while high
    set_map(0, 1, 2, 3);
    step({{(NP-1){1'b0}}, 1'b1}, "R10 setup");       // dev0 pin0 -> root 0 -> line 0
    set_map(1, 1, 2, 3);
    step('0, "R10 fall clamps at zero");             // line 1 stays 0, line 0 stuck
    step({{(NP-1){1'b0}}, 1'b1}, "R10 rise after clamp");
    step('0, "R10 fall after clamp");

    // R5 mid-run reset
    step({NP{1'b1}}, "R5 load before reset");
    rst_n = 1'b0;
    irq = '0;
    clear_model();
    @(negedge clk);
    check_lines("R5 mid-run reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_lines("R5 release idle");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule